// File: doc/BRIEF.md
# Configuration Packet Command Processor

This block takes in a configuration stream of 16-bit words, one word per cycle in which `in_valid` is high. After reset it is hunting. In that state it throws away padding words of any value until it sees the two-word sync marker: 0xAA99 in one word and 0x5566 in the next word it accepts. Once synchronised, it reads each following word as a packet header. A header becomes a register read request, a run of register writes, a no-op, or a bulk transfer that streams raw frame words out of a separate port.

The header layout is, from the most significant bit down: type[15:13], opcode[12:11], register[10:5], count[4:0]. A type-1 write carries `count` payload words. Each payload word is presented on the register port with its own strobe, and the register number stays the same for the whole packet. A type-2 write ignores the header count. Its length is the 32-bit value formed by the next two words, high word first; the top four bits of that value must be zero. That many data words then go to the frame port.

If the value 0x000D is written to command register 0x05, the block drops back to hunting. A malformed header or length sets a sticky error flag and also sends the block back to hunting.

The FSM states are HUNT, SYNC2, HDR, T1_DATA, LEN_HI, LEN_LO and BULK. Their transitions are:
- HUNT goes to SYNC2 on 0xAA99.
- SYNC2 goes to HDR on 0x5566, stays in SYNC2 on another 0xAA99, and goes back to HUNT on any other word.
- HDR goes to T1_DATA on a type-1 write with a nonzero count, and to LEN_HI on a type-2 write. It goes to HUNT on a bad header. On anything else it stays in HDR.
- T1_DATA goes to HDR after its last word, or to HUNT on DESYNC.
- LEN_HI goes to LEN_LO, or to HUNT when the length is bad.
- LEN_LO goes to BULK, or to HDR when the length is zero.
- BULK goes to HDR after its last word.

Top module: `cfg_pkt_engine`

## Requirements
- R1: While hunting, words are ignored until 0xAA99 is followed directly by accepted word 0x5566. A repeated 0xAA99 keeps the first half of the marker. Any other word after 0xAA99 restarts the hunt.
- R2: `synced` is 1 from the cycle after the 0x5566 word is accepted until the session ends. The word after the sync marker is decoded as a header with type[15:13], opcode[12:11] (0 no-op, 1 read, 2 write), register[10:5] and count[4:0].
- R3: A type-1 write with count N gives N pulses of `reg_wr_en`, one per accepted payload word. Each pulse comes in the cycle after its word, with that word on `reg_wr_data` and the header register on `reg_addr`.
- R4: A type-1 read gives one `reg_rd_en` pulse with the register on `reg_addr`, in the cycle after the header, and takes no payload words.
- R5: A type-1 no-op header produces no strobe, and the next word is decoded as a header.
- R6: A type-2 write takes length = {word1, word2} from the next two words and ignores the header count. Each of the following `length` words then appears on `frame_data`, with `frame_valid` high in the cycle after the word.
- R7: A type-1 write of 0x000D to register 0x05 still gives its strobe, and `synced` drops in that same cycle. Words are then ignored until a new sync marker. A different value written to 0x05 keeps the block synchronised.
- R8: A header whose type is not 1 or 2, or with opcode 3, or a type-2 header whose opcode is not write, or a length with nonzero bits [31:28] sets `err_flag` and returns the block to hunting. `err_flag` stays set until the next complete sync marker.
- R9: A cycle with `in_valid` low produces no strobe and changes no state.
- R10: After reset all strobes, `synced` and `err_flag` are 0 and the block is hunting.
- R11: A type-1 write with count 0, or a type-2 write with length 0, takes no payload words, and the next word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_word | input | 16 | Configuration stream word |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read request strobe |
| reg_addr | output | 6 | Register number of the current packet |
| reg_wr_data | output | 16 | Register write data |
| frame_valid | output | 1 | Frame data word strobe |
| frame_data | output | 16 | Frame data word |
| synced | output | 1 | Block is synchronised and decoding packets |
| err_flag | output | 1 | Sticky protocol error, cleared by the next sync |

## Verification
If the block has locked onto the wrong state, the next accepted word shows it at the ports. A payload word can appear as a header, which loses a strobe or produces a `reg_rd_en` pulse that should not be there. A header can appear as payload, which gives a write strobe carrying the header value. A miscounted length moves a packet boundary. The following header then leaks onto `frame_data`, or the first frame word is decoded as a header and usually raises `err_flag` within one word. The bench walks packets back to back, so every boundary is checked on the first word after it.

// File: rtl/cfg_pkt_pkg.sv
package cfg_pkt_pkg;

    localparam int WORD_W   = 16;
    localparam int REG_W    = 6;
    localparam int CNT_W    = 5;
    localparam int LEN_BITS = 28;  // usable bits of the 32-bit bulk length
    localparam int LEN_HI_W = LEN_BITS - WORD_W;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYNC2,
        ST_HDR,
        ST_T1_DATA,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_BULK
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } opcode_t;

    typedef struct packed {
        logic [2:0]       ptype;
        opcode_t          op;
        logic [REG_W-1:0] reg_id;
        logic [CNT_W-1:0] count;
    } hdr_t;

endpackage

// File: rtl/cfg_hdr_split.sv
module cfg_hdr_split
    import cfg_pkt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr,
    output logic              is_t1,
    output logic              is_t2,
    output logic              bad
);
    always_comb begin
        hdr   = hdr_t'(word);
        is_t1 = (hdr.ptype == 3'd1);
        is_t2 = (hdr.ptype == 3'd2);
        bad   = !(is_t1 || is_t2) || (hdr.op == OP_RSVD)
                || (is_t2 && hdr.op != OP_WRITE);
    end
endmodule

// File: rtl/cfg_word_counter.sv
module cfg_word_counter #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign is_last = (cnt_q == W'(1));
endmodule

// File: rtl/cfg_pkt_engine.sv
module cfg_pkt_engine
    import cfg_pkt_pkg::*;
#(
    parameter logic [15:0] SYNC_HI     = 16'hAA99,
    parameter logic [15:0] SYNC_LO     = 16'h5566,
    parameter logic [5:0]  CMD_REG     = 6'h05,
    parameter logic [15:0] DESYNC_CODE = 16'h000D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    output logic        reg_wr_en,
    output logic        reg_rd_en,
    output logic [5:0]  reg_addr,
    output logic [15:0] reg_wr_data,
    output logic        frame_valid,
    output logic [15:0] frame_data,
    output logic        synced,
    output logic        err_flag
);
    eng_state_t          st_q, st_d;
    hdr_t                hdr;
    logic                is_t1, is_t2, hdr_bad;
    logic [REG_W-1:0]    reg_q;
    logic [LEN_HI_W-1:0] len_hi_q;
    logic                cnt_load, cnt_dec, cnt_last;
    logic [LEN_BITS-1:0] cnt_val;
    logic                len_bad, len_zero, desync_hit;

    cfg_hdr_split u_split (
        .word  (in_word),
        .hdr   (hdr),
        .is_t1 (is_t1),
        .is_t2 (is_t2),
        .bad   (hdr_bad)
    );

    cfg_word_counter #(.W(LEN_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .is_last  (cnt_last)
    );

    assign len_bad    = (in_word[WORD_W-1:LEN_HI_W] != '0);
    assign len_zero   = ({len_hi_q, in_word} == '0);
    assign desync_hit = (reg_q == CMD_REG) && (in_word == DESYNC_CODE);

    // counter control: loaded at a counted header or at the low length word
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        if (in_valid) begin
            if (st_q == ST_HDR && !hdr_bad && is_t1 && hdr.op == OP_WRITE) begin
                cnt_load = 1'b1;
                cnt_val  = LEN_BITS'(hdr.count);
            end else if (st_q == ST_LEN_LO) begin
                cnt_load = 1'b1;
                cnt_val  = {len_hi_q, in_word};
            end
            cnt_dec = (st_q == ST_T1_DATA) || (st_q == ST_BULK);
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            unique case (st_q)
                ST_HUNT:    if (in_word == SYNC_HI) st_d = ST_SYNC2;
                ST_SYNC2: begin
                    if (in_word == SYNC_LO)      st_d = ST_HDR;
                    else if (in_word == SYNC_HI) st_d = ST_SYNC2;
                    else                         st_d = ST_HUNT;
                end
                ST_HDR: begin
                    if (hdr_bad)                                    st_d = ST_HUNT;
                    else if (is_t2)                                 st_d = ST_LEN_HI;
                    else if (hdr.op == OP_WRITE && hdr.count != '0) st_d = ST_T1_DATA;
                    else                                            st_d = ST_HDR;
                end
                ST_T1_DATA: begin
                    if (desync_hit)    st_d = ST_HUNT;
                    else if (cnt_last) st_d = ST_HDR;
                end
                ST_LEN_HI:  st_d = len_bad ? ST_HUNT : ST_LEN_LO;
                ST_LEN_LO:  st_d = len_zero ? ST_HDR : ST_BULK;
                ST_BULK:    if (cnt_last) st_d = ST_HDR;
                default:    st_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // registered outputs and packet context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_wr_en   <= 1'b0;
            reg_rd_en   <= 1'b0;
            frame_valid <= 1'b0;
            reg_wr_data <= '0;
            frame_data  <= '0;
            reg_q       <= '0;
            len_hi_q    <= '0;
            err_flag    <= 1'b0;
        end else begin
            reg_wr_en   <= 1'b0;
            reg_rd_en   <= 1'b0;
            frame_valid <= 1'b0;
            if (in_valid) begin
                unique case (st_q)
                    ST_SYNC2: if (in_word == SYNC_LO) err_flag <= 1'b0;
                    ST_HDR: begin
                        reg_q <= hdr.reg_id;
                        if (hdr_bad) err_flag <= 1'b1;
                        else         reg_rd_en <= is_t1 && (hdr.op == OP_READ);
                    end
                    ST_T1_DATA: begin
                        reg_wr_en   <= 1'b1;
                        reg_wr_data <= in_word;
                    end
                    ST_LEN_HI: begin
                        len_hi_q <= in_word[LEN_HI_W-1:0];
                        if (len_bad) err_flag <= 1'b1;
                    end
                    ST_BULK: begin
                        frame_valid <= 1'b1;
                        frame_data  <= in_word;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_addr = reg_q;
    assign synced   = (st_q != ST_HUNT) && (st_q != ST_SYNC2);

endmodule

// File: rtl/cfg_pkt_engine_chk.sv
module cfg_pkt_engine_chk #(
    parameter logic [15:0] SYNC_LO     = 16'h5566,
    parameter logic [5:0]  CMD_REG     = 6'h05,
    parameter logic [15:0] DESYNC_CODE = 16'h000D
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_word,
    input logic        reg_wr_en,
    input logic        reg_rd_en,
    input logic [5:0]  reg_addr,
    input logic [15:0] reg_wr_data,
    input logic        frame_valid,
    input logic        synced,
    input logic        err_flag
);
    // R1: lock only follows an accepted second sync word
    a_r1_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> ($past(in_valid) && $past(in_word) == SYNC_LO));

    // R3 / R4 / R6: at most one kind of strobe per cycle
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en, frame_valid}));

    // R7: the DESYNC write strobe coincides with loss of sync
    a_r7_desync_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == CMD_REG && reg_wr_data == DESYNC_CODE) |-> !synced);

    // R8: a newly raised error leaves the block hunting
    a_r8_err_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !synced);

    // R9: no strobe without an accepted word in the previous cycle
    a_r9_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !(reg_wr_en || reg_rd_en || frame_valid));

    // R6: frame words only flow while synchronised
    a_r6_frame_synced: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> synced);
endmodule

bind cfg_pkt_engine cfg_pkt_engine_chk #(
    .SYNC_LO     (SYNC_LO),
    .CMD_REG     (CMD_REG),
    .DESYNC_CODE (DESYNC_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .frame_valid (frame_valid),
    .synced      (synced),
    .err_flag    (err_flag)
);

// File: tb/test_cfg_pkt_engine.sv
module test_cfg_pkt_engine;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        reg_wr_en, reg_rd_en, frame_valid, synced, err_flag;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wr_data, frame_data;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_pkt_engine i_cfg_pkt_engine (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_word (in_word),
        .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en), .reg_addr (reg_addr),
        .reg_wr_data (reg_wr_data), .frame_valid (frame_valid),
        .frame_data (frame_data), .synced (synced), .err_flag (err_flag)
    );

    typedef struct packed {
        logic [15:0] w;
        logic        wr;
        logic [5:0]  a;
        logic [15:0] d;
        logic        fv;
        logic        sy;
        logic        er;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{16'hFFFF, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{16'hFFFF, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{16'hAA99, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{16'h5566, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'h31E1, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'hFFFF, 1'b1, 6'h0F, 16'hFFFF, 1'b0, 1'b1, 1'b0},
        '{16'h3022, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'h0000, 1'b1, 6'h01, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'h0123, 1'b1, 6'h01, 16'h0123, 1'b0, 1'b1, 1'b0},
        '{16'h2000, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'h507F, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'h0000, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'h0002, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'hBEEF, 1'b0, 6'h00, 16'hBEEF, 1'b1, 1'b1, 1'b0},
        '{16'hCAFE, 1'b0, 6'h00, 16'hCAFE, 1'b1, 1'b1, 1'b0},
        '{16'h30A1, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b1, 1'b0},
        '{16'h000D, 1'b1, 6'h05, 16'h000D, 1'b0, 1'b0, 1'b0},
        '{16'h3021, 1'b0, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] w);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input logic [15:0] w);
        in_valid = 1'b0;
        in_word  = w;
        @(negedge clk);
    endtask

    task automatic strobes(input string tag, input logic wr, input logic rd, input logic fv);
        check({tag, " wr"}, 32'(reg_wr_en), 32'(wr));
        check({tag, " rd"}, 32'(reg_rd_en), 32'(rd));
        check({tag, " fv"}, 32'(frame_valid), 32'(fv));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        strobes("R10 reset", 1'b0, 1'b0, 1'b0);
        check("R10 reset synced", 32'(synced), 0);
        check("R10 reset err", 32'(err_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table: R1 sync, R2 decode, R3 writes, R5 nop, R6 bulk, R7 desync
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].w);
            check($sformatf("R1/R2/R3/R5/R6/R7 vec%0d wr", i), 32'(reg_wr_en), 32'(TBL[i].wr));
            check($sformatf("R1/R2/R3/R5/R6/R7 vec%0d fv", i), 32'(frame_valid), 32'(TBL[i].fv));
            check($sformatf("R1/R2/R7 vec%0d synced", i), 32'(synced), 32'(TBL[i].sy));
            check($sformatf("R8 vec%0d err", i), 32'(err_flag), 32'(TBL[i].er));
            if (TBL[i].wr) begin
                check($sformatf("R3 vec%0d addr", i), 32'(reg_addr), 32'(TBL[i].a));
                check($sformatf("R3 vec%0d data", i), 32'(reg_wr_data), 32'(TBL[i].d));
            end
            if (TBL[i].fv)
                check($sformatf("R6 vec%0d frame", i), 32'(frame_data), 32'(TBL[i].d));
        end

        // R1 false start, then repeated first half
        step(16'hAA99); step(16'h1234);
        check("R1 broken marker", 32'(synced), 0);
        step(16'h5566);
        check("R1 lone second half", 32'(synced), 0);
        step(16'hAA99); step(16'hAA99); step(16'h5566);
        check("R1 repeated first half", 32'(synced), 1);

        // R4 read of register 0x0E
        step(16'h29C0);
        strobes("R4 read", 1'b0, 1'b1, 1'b0);
        check("R4 read addr", 32'(reg_addr), 32'h0E);

        // R11 zero count write, next word is a header
        step(16'h30A0);
        strobes("R11 zero count", 1'b0, 1'b0, 1'b0);
        step(16'h3021); step(16'h7777);
        strobes("R11 header after zero count", 1'b1, 1'b0, 1'b0);
        check("R11 data", 32'(reg_wr_data), 32'h7777);

        // R9 stall inside a two-word write to 0x0F
        step(16'h31E2); step(16'h1111);
        strobes("R9 first word", 1'b1, 1'b0, 1'b0);
        idle(16'h9999);
        strobes("R9 idle", 1'b0, 1'b0, 1'b0);
        step(16'h2222);
        strobes("R9 second word", 1'b1, 1'b0, 1'b0);
        check("R9 addr held", 32'(reg_addr), 32'h0F);
        check("R9 data", 32'(reg_wr_data), 32'h2222);

        // R11 zero-length bulk, then nop and non-desync command
        step(16'h5060); step(16'h0000); step(16'h0000);
        step(16'h2000);
        strobes("R11 zero length then nop", 1'b0, 1'b0, 1'b0);
        step(16'h30A1); step(16'h0007);
        strobes("R7 other command", 1'b1, 1'b0, 1'b0);
        check("R7 other command synced", 32'(synced), 1);

        // R8 bad length, sticky flag, cleared by sync
        step(16'h5060); step(16'h1000);
        check("R8 bad length err", 32'(err_flag), 1);
        check("R8 bad length synced", 32'(synced), 0);
        step(16'h3021); step(16'h4444);
        strobes("R8 ignored while hunting", 1'b0, 1'b0, 1'b0);
        check("R8 err sticky", 32'(err_flag), 1);
        step(16'hAA99); step(16'h5566);
        check("R8 err cleared by sync", 32'(err_flag), 0);

        // R8 bad type, then type-2 read
        step(16'h6000);
        check("R8 bad type err", 32'(err_flag), 1);
        check("R8 bad type synced", 32'(synced), 0);
        step(16'hAA99); step(16'h5566);
        step(16'h4800);
        check("R8 type2 read err", 32'(err_flag), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule